// File: doc/BRIEF.md
# Programmable Priority Interrupt Controller

This block ranks interrupt requests for a small microcontroller. Software programs a 4-bit rank for every source through a 16-bit register bus. The block then presents the strongest pending request, as a source index and a rank, to a CPU that compares the rank with its own mask. Four active-low request pins (IRQ0 to IRQ3) each own one rank field. Peripheral request lines arrive in pairs, and each pair shares one field, so both lines of a pair always carry the same rank. A non-maskable input (NMI) beats every maskable request.

A control register selects how each input is detected: by level or by edge for the IRQ pins, and by rising or falling edge for NMI. The same register also shows the live NMI pin level. Each edge-detecting input has a small per-input state machine, `irq_edge_fsm`, with three states:

- `EDG_IDLE`: waiting for the line to go inactive.
- `EDG_ARMED`: the line is inactive and the next active edge is awaited.
- `EDG_LATCHED`: an edge has been caught and is held until acknowledged.

Its transitions are:

- `IDLE->ARMED` when the line is seen inactive.
- `ARMED->LATCHED` on the active edge.
- `ARMED->IDLE` when the edge arrives together with an acknowledge.
- `LATCHED->ARMED` or `LATCHED->IDLE` on acknowledge, depending on the line level at that moment.
- `any->IDLE` on hardware standby, on a control-register write, or when level mode is selected.

All inputs are assumed to be synchronous to `clk`. `NUM_PRIO_REGS` must be at least 2.

Top module: `irq_prio_ctrl`

## Requirements
- R1: Bus address r (r < NUM_PRIO_REGS) selects priority register r, and address NUM_PRIO_REGS selects the control register. Field f of register r, at bits 4f+3:4f, holds the rank of source 4r+f. A written priority value reads back unchanged. Reads are combinational.
- R2: A pending source whose rank is 0 is never presented. When no request is presented, `out_valid_o` is 0 and the source and rank outputs are 0.
- R3: The pending source with the highest rank wins. Among equal ranks, the lower source index wins.
- R4: Source 4+j (j >= 0) is pending whenever peripheral line 2j or line 2j+1 is high, so both lines of the pair share one rank.
- R5: A hardware reset (`rst_n` low) or a `hw_standby_i` cycle clears every priority register and every control mode bit to 0, and drops the presented request.
- R6: While `sw_standby_i` is high, the registers keep their values and the presented source and rank hold.
- R7: Control bit 15 reads the live NMI pin level (1 = high). Writing that bit has no effect.
- R8: Control bits 14:9 and 3:0 read 0 whatever is written. Bit 8 is the NMI edge select. Bits 7, 6, 5 and 4 are the mode bits of IRQ0, IRQ1, IRQ2 and IRQ3. All of these mode bits read back as written.
- R9: With its mode bit 0, IRQn is pending exactly while its pin is low. A low pulse is not remembered.
- R10: With its mode bit 1, a falling edge on IRQn is latched and stays pending after the pin returns high. It is cleared by `ack_i` with `ack_src_i` = n, and the request is gone two clocks after the acknowledge cycle.
- R11: NMI is latched on a falling edge when bit 8 is 0 and on a rising edge when bit 8 is 1; the opposite edge is ignored. It is cleared by `ack_i` with `ack_src_i` = 4*NUM_PRIO_REGS.
- R12: A pending NMI always wins and is presented as source 4*NUM_PRIO_REGS with rank 16.
- R13: The presented source and rank are registered. They change one clock after a request changes, and one clock after the write edge of a register write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low hardware reset |
| hw_standby_i | input | 1 | Hardware standby; clears registers and detectors |
| sw_standby_i | input | 1 | Software standby; registers kept, outputs held |
| bus_sel_i | input | 1 | Bus access strobe |
| bus_wr_i | input | 1 | 1 = write access |
| bus_addr_i | input | $clog2(NUM_PRIO_REGS+1) | Register address |
| bus_wdata_i | input | 16 | Write data |
| bus_rdata_o | output | 16 | Read data (combinational) |
| nmi_pin_i | input | 1 | Non-maskable interrupt pin |
| irq_n_i | input | 4 | Active-low request pins IRQ0..IRQ3 (bit n = IRQn) |
| periph_req_i | input | 8*NUM_PRIO_REGS-8 | Active-high peripheral request lines |
| ack_i | input | 1 | Acknowledge strobe |
| ack_src_i | input | $clog2(4*NUM_PRIO_REGS+1) | Source being acknowledged |
| out_valid_o | output | 1 | A request is presented |
| out_src_o | output | $clog2(4*NUM_PRIO_REGS+1) | Winning source index |
| out_rank_o | output | 5 | Winning rank (16 for NMI) |

## Verification
Winner outputs are due one rising edge after a pin, a peripheral line or a latched edge changes, and one edge after the edge that performs a register write. A cleared edge latch shows up two edges after the acknowledge cycle, and register reads are due in the same cycle. The bench drives every stimulus on a falling edge. It samples the winner at the next falling edge, or at the second one for acknowledges. It also samples once right after a write, to confirm the old winner is still shown there. Reads are sampled one time unit after the address is set, with no clock edge in between.

// File: rtl/irq_prio_pkg.sv
package irq_prio_pkg;
    localparam int FIELD_W        = 4;
    localparam int FIELDS_PER_REG = 4;
    localparam int NUM_PINS       = 4;
    localparam int DATA_W         = 16;
    localparam int RANK_W         = FIELD_W + 1;
    localparam int CTRL_NMI_LVL   = 15;
    localparam int CTRL_NMI_MODE  = 8;
    localparam int CTRL_IRQ_MSB   = 7;
    localparam logic [RANK_W-1:0] NMI_RANK = RANK_W'(16);

    typedef enum logic [1:0] {
        EDG_IDLE    = 2'd0,
        EDG_ARMED   = 2'd1,
        EDG_LATCHED = 2'd2
    } edge_state_e;
endpackage

// File: rtl/irq_edge_fsm.sv
module irq_edge_fsm
    import irq_prio_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic clr_i,
    input  logic enable_i,
    input  logic line_hi_i,
    input  logic ack_i,
    output logic pending_o
);
    edge_state_e state_q;
    edge_state_e state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= EDG_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        if (clr_i || !enable_i) begin
            state_d = EDG_IDLE;
        end else begin
            unique case (state_q)
                EDG_IDLE: begin
                    if (line_hi_i) state_d = EDG_ARMED;
                end
                EDG_ARMED: begin
                    if (!line_hi_i) state_d = ack_i ? EDG_IDLE : EDG_LATCHED;
                end
                EDG_LATCHED: begin
                    if (ack_i) state_d = line_hi_i ? EDG_ARMED : EDG_IDLE;
                end
                default: state_d = EDG_IDLE;
            endcase
        end
    end

    always_comb begin
        pending_o = 1'b0;
        unique case (state_q)
            EDG_IDLE:    pending_o = 1'b0;
            EDG_ARMED:   pending_o = enable_i & ~line_hi_i;
            EDG_LATCHED: pending_o = enable_i;
            default:     pending_o = 1'b0;
        endcase
    end
endmodule

// File: rtl/irq_prio_regs.sv
module irq_prio_regs
    import irq_prio_pkg::*;
#(
    parameter int NUM_PRIO_REGS = 3,
    parameter int ADDR_W        = 2
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              hw_standby_i,
    input  logic                              bus_sel_i,
    input  logic                              bus_wr_i,
    input  logic [ADDR_W-1:0]                 bus_addr_i,
    input  logic [DATA_W-1:0]                 bus_wdata_i,
    output logic [DATA_W-1:0]                 bus_rdata_o,
    input  logic                              nmi_pin_i,
    output logic [NUM_PRIO_REGS*DATA_W-1:0]   prio_flat_o,
    output logic                              nmi_mode_o,
    output logic [NUM_PINS-1:0]               irq_mode_o,
    output logic                              ctrl_wr_o
);
    localparam logic [ADDR_W-1:0] CTRL_ADDR = ADDR_W'(NUM_PRIO_REGS);

    logic wr_en;
    assign wr_en     = bus_sel_i & bus_wr_i;
    assign ctrl_wr_o = wr_en && (bus_addr_i == CTRL_ADDR);

    for (genvar r = 0; r < NUM_PRIO_REGS; r++) begin : g_prio
        logic [DATA_W-1:0] prio_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                prio_q <= '0;
            end else if (hw_standby_i) begin
                prio_q <= '0;
            end else if (wr_en && (bus_addr_i == ADDR_W'(r))) begin
                prio_q <= bus_wdata_i;
            end
        end
        assign prio_flat_o[r*DATA_W +: DATA_W] = prio_q;
    end

    logic                nmi_mode_q;
    logic [NUM_PINS-1:0] irq_mode_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            nmi_mode_q <= 1'b0;
            irq_mode_q <= '0;
        end else if (hw_standby_i) begin
            nmi_mode_q <= 1'b0;
            irq_mode_q <= '0;
        end else if (ctrl_wr_o) begin
            nmi_mode_q <= bus_wdata_i[CTRL_NMI_MODE];
            for (int n = 0; n < NUM_PINS; n++) begin
                irq_mode_q[n] <= bus_wdata_i[CTRL_IRQ_MSB-n];
            end
        end
    end

    assign nmi_mode_o = nmi_mode_q;
    assign irq_mode_o = irq_mode_q;

    always_comb begin
        bus_rdata_o = '0;
        if (bus_addr_i == CTRL_ADDR) begin
            bus_rdata_o[CTRL_NMI_LVL]  = nmi_pin_i;
            bus_rdata_o[CTRL_NMI_MODE] = nmi_mode_q;
            for (int n = 0; n < NUM_PINS; n++) begin
                bus_rdata_o[CTRL_IRQ_MSB-n] = irq_mode_q[n];
            end
        end else begin
            for (int r = 0; r < NUM_PRIO_REGS; r++) begin
                if (bus_addr_i == ADDR_W'(r)) begin
                    bus_rdata_o = prio_flat_o[r*DATA_W +: DATA_W];
                end
            end
        end
    end
endmodule

// File: rtl/irq_prio_resolve.sv
module irq_prio_resolve
    import irq_prio_pkg::*;
#(
    parameter int NUM_FIELDS = 12,
    parameter int SRC_W      = 4
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          clr_i,
    input  logic                          hold_i,
    input  logic [NUM_FIELDS-1:0]         req_i,
    input  logic [NUM_FIELDS*FIELD_W-1:0] rank_flat_i,
    input  logic                          nmi_req_i,
    output logic                          out_valid_o,
    output logic [SRC_W-1:0]              out_src_o,
    output logic [RANK_W-1:0]             out_rank_o
);
    logic [RANK_W-1:0] win_rank;
    logic [SRC_W-1:0]  win_src;

    always_comb begin
        win_rank = '0;
        win_src  = '0;
        for (int k = 0; k < NUM_FIELDS; k++) begin
            if (req_i[k] && ({1'b0, rank_flat_i[k*FIELD_W +: FIELD_W]} > win_rank)) begin
                win_rank = {1'b0, rank_flat_i[k*FIELD_W +: FIELD_W]};
                win_src  = SRC_W'(k);
            end
        end
        if (nmi_req_i) begin
            win_rank = NMI_RANK;
            win_src  = SRC_W'(NUM_FIELDS);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_valid_o <= 1'b0;
            out_src_o   <= '0;
            out_rank_o  <= '0;
        end else if (clr_i) begin
            out_valid_o <= 1'b0;
            out_src_o   <= '0;
            out_rank_o  <= '0;
        end else if (!hold_i) begin
            out_valid_o <= (win_rank != '0);
            out_src_o   <= win_src;
            out_rank_o  <= win_rank;
        end
    end
endmodule

// File: rtl/irq_prio_ctrl.sv
module irq_prio_ctrl
    import irq_prio_pkg::*;
#(
    parameter  int NUM_PRIO_REGS = 3,
    localparam int NUM_FIELDS    = NUM_PRIO_REGS * FIELDS_PER_REG,
    localparam int NUM_PERIPH    = 2 * (NUM_FIELDS - NUM_PINS),
    localparam int SRC_W         = $clog2(NUM_FIELDS + 1),
    localparam int ADDR_W        = $clog2(NUM_PRIO_REGS + 1)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  hw_standby_i,
    input  logic                  sw_standby_i,
    input  logic                  bus_sel_i,
    input  logic                  bus_wr_i,
    input  logic [ADDR_W-1:0]     bus_addr_i,
    input  logic [DATA_W-1:0]     bus_wdata_i,
    output logic [DATA_W-1:0]     bus_rdata_o,
    input  logic                  nmi_pin_i,
    input  logic [NUM_PINS-1:0]   irq_n_i,
    input  logic [NUM_PERIPH-1:0] periph_req_i,
    input  logic                  ack_i,
    input  logic [SRC_W-1:0]      ack_src_i,
    output logic                  out_valid_o,
    output logic [SRC_W-1:0]      out_src_o,
    output logic [RANK_W-1:0]     out_rank_o
);
    logic [NUM_PRIO_REGS*DATA_W-1:0] prio_flat;
    logic                            nmi_mode;
    logic [NUM_PINS-1:0]             irq_mode;
    logic                            ctrl_wr;
    logic                            det_clr;
    logic [NUM_FIELDS-1:0]           req;
    logic                            nmi_req;

    assign det_clr = hw_standby_i | ctrl_wr;

    irq_prio_regs #(
        .NUM_PRIO_REGS (NUM_PRIO_REGS),
        .ADDR_W        (ADDR_W)
    ) u_regs (
        .clk          (clk),
        .rst_n        (rst_n),
        .hw_standby_i (hw_standby_i),
        .bus_sel_i    (bus_sel_i),
        .bus_wr_i     (bus_wr_i),
        .bus_addr_i   (bus_addr_i),
        .bus_wdata_i  (bus_wdata_i),
        .bus_rdata_o  (bus_rdata_o),
        .nmi_pin_i    (nmi_pin_i),
        .prio_flat_o  (prio_flat),
        .nmi_mode_o   (nmi_mode),
        .irq_mode_o   (irq_mode),
        .ctrl_wr_o    (ctrl_wr)
    );

    for (genvar n = 0; n < NUM_PINS; n++) begin : g_pin
        logic edge_pend;
        irq_edge_fsm u_edge (
            .clk       (clk),
            .rst_n     (rst_n),
            .clr_i     (det_clr),
            .enable_i  (irq_mode[n]),
            .line_hi_i (irq_n_i[n]),
            .ack_i     (ack_i && (ack_src_i == SRC_W'(n))),
            .pending_o (edge_pend)
        );
        assign req[n] = irq_mode[n] ? edge_pend : ~irq_n_i[n];
    end

    for (genvar k = NUM_PINS; k < NUM_FIELDS; k++) begin : g_periph
        assign req[k] = |periph_req_i[2*(k-NUM_PINS) +: 2];
    end

    irq_edge_fsm u_nmi_edge (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr_i     (det_clr),
        .enable_i  (1'b1),
        .line_hi_i (nmi_pin_i ^ nmi_mode),
        .ack_i     (ack_i && (ack_src_i == SRC_W'(NUM_FIELDS))),
        .pending_o (nmi_req)
    );

    irq_prio_resolve #(
        .NUM_FIELDS (NUM_FIELDS),
        .SRC_W      (SRC_W)
    ) u_resolve (
        .clk         (clk),
        .rst_n       (rst_n),
        .clr_i       (hw_standby_i),
        .hold_i      (sw_standby_i),
        .req_i       (req),
        .rank_flat_i (prio_flat),
        .nmi_req_i   (nmi_req),
        .out_valid_o (out_valid_o),
        .out_src_o   (out_src_o),
        .out_rank_o  (out_rank_o)
    );
endmodule

// File: rtl/irq_prio_chk.sv
module irq_prio_chk
    import irq_prio_pkg::*;
#(
    parameter  int NUM_PRIO_REGS = 3,
    localparam int NUM_FIELDS    = NUM_PRIO_REGS * FIELDS_PER_REG,
    localparam int SRC_W         = $clog2(NUM_FIELDS + 1),
    localparam int ADDR_W        = $clog2(NUM_PRIO_REGS + 1)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              hw_standby_i,
    input logic              sw_standby_i,
    input logic [ADDR_W-1:0] bus_addr_i,
    input logic [DATA_W-1:0] bus_rdata_o,
    input logic              nmi_pin_i,
    input logic              out_valid_o,
    input logic [SRC_W-1:0]  out_src_o,
    input logic [RANK_W-1:0] out_rank_o
);
    localparam logic [ADDR_W-1:0] CTRL_ADDR = ADDR_W'(NUM_PRIO_REGS);
    localparam logic [SRC_W-1:0]  NMI_SRC   = SRC_W'(NUM_FIELDS);

    // R2
    rank_zero_hidden_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid_o |-> (out_rank_o != '0));

    // R12
    nmi_rank_fixed_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid_o && out_src_o == NMI_SRC) |-> (out_rank_o == NMI_RANK));

    // R7
    nmi_level_mirror_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr_i == CTRL_ADDR) |-> (bus_rdata_o[CTRL_NMI_LVL] == nmi_pin_i));

    // R8
    reserved_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr_i == CTRL_ADDR) |-> (bus_rdata_o[14:9] == '0 && bus_rdata_o[3:0] == '0));

    // R5
    standby_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hw_standby_i |=> (!out_valid_o && (bus_addr_i == CTRL_ADDR || bus_rdata_o == '0)));

    // R6
    sw_standby_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(sw_standby_i) |-> ($stable(out_src_o) && $stable(out_rank_o) && $stable(out_valid_o)));
endmodule

bind irq_prio_ctrl irq_prio_chk #(.NUM_PRIO_REGS(NUM_PRIO_REGS)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .hw_standby_i (hw_standby_i),
    .sw_standby_i (sw_standby_i),
    .bus_addr_i   (bus_addr_i),
    .bus_rdata_o  (bus_rdata_o),
    .nmi_pin_i    (nmi_pin_i),
    .out_valid_o  (out_valid_o),
    .out_src_o    (out_src_o),
    .out_rank_o   (out_rank_o)
);

// File: tb/irq_prio_ctrl_tb.sv
module irq_prio_ctrl_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        hw_standby = 1'b0;
    logic        sw_standby = 1'b0;
    logic        bus_sel = 1'b0;
    logic        bus_wr = 1'b0;
    logic [1:0]  bus_addr = '0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic        nmi_pin = 1'b1;
    logic [3:0]  irq_n = 4'b1111;
    logic [15:0] periph = '0;
    logic        ack = 1'b0;
    logic [3:0]  ack_src = '0;
    logic        out_valid;
    logic [3:0]  out_src;
    logic [4:0]  out_rank;

    int n_checks = 0;
    int n_err    = 0;
    bit done     = 1'b0;

    always #2 clk = ~clk;

    irq_prio_ctrl #(.NUM_PRIO_REGS(3)) u_dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .hw_standby_i (hw_standby),
        .sw_standby_i (sw_standby),
        .bus_sel_i    (bus_sel),
        .bus_wr_i     (bus_wr),
        .bus_addr_i   (bus_addr),
        .bus_wdata_i  (bus_wdata),
        .bus_rdata_o  (bus_rdata),
        .nmi_pin_i    (nmi_pin),
        .irq_n_i      (irq_n),
        .periph_req_i (periph),
        .ack_i        (ack),
        .ack_src_i    (ack_src),
        .out_valid_o  (out_valid),
        .out_src_o    (out_src),
        .out_rank_o   (out_rank)
    );

    // {irq_n, periph, valid, src, rank}; ranks: IRQ0=1 IRQ1=2 IRQ2=5 IRQ3=3,
    // src4=5 src5=0 src6=10 src7=0 src8=10 src9=0 src10=0 src11=15
    localparam logic [29:0] VEC [12] = '{
        {4'b1111, 16'h0000, 1'b0, 4'd0,  5'd0 },  // R2 idle
        {4'b1110, 16'h0000, 1'b1, 4'd0,  5'd1 },  // R9
        {4'b1100, 16'h0000, 1'b1, 4'd1,  5'd2 },  // R3
        {4'b1011, 16'h0000, 1'b1, 4'd2,  5'd5 },  // R9
        {4'b1011, 16'h0001, 1'b1, 4'd2,  5'd5 },  // R3 tie
        {4'b1111, 16'h0002, 1'b1, 4'd4,  5'd5 },  // R4 second line
        {4'b1111, 16'h0004, 1'b0, 4'd0,  5'd0 },  // R2 rank 0
        {4'b1111, 16'h0110, 1'b1, 4'd6,  5'd10},  // R3 tie
        {4'b1111, 16'h8020, 1'b1, 4'd11, 5'd15},  // R4
        {4'b0000, 16'hFFFF, 1'b1, 4'd11, 5'd15},  // R3
        {4'b0111, 16'h0008, 1'b1, 4'd3,  5'd3 },  // R2
        {4'b1111, 16'h0000, 1'b0, 4'd0,  5'd0 }   // R9
    };

    task automatic chk(input string tag, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic chk_out(input string tag, input logic v, input int s, input int r);
        chk(tag, {out_valid, out_src, out_rank}, {v, 4'(s), 5'(r)});
    endtask

    task automatic bus_write(input logic [1:0] a, input logic [15:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic chk_read(input string tag, input logic [1:0] a, input logic [15:0] exp);
        bus_addr = a;
        #1;
        chk(tag, bus_rdata, exp);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("  CHECKS %0d ERRORS %0d", n_checks, n_err);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_checks++;
        n_err++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R5: reset state
        chk_out("R5 reset out", 1'b0, 0, 0);
        chk_read("R5 reset reg0", 2'd0, 16'h0000);
        chk_read("R5 reset reg2", 2'd2, 16'h0000);
        chk_read("R5 reset ctrl", 2'd3, 16'h8000);

        // R1: program and read back
        bus_write(2'd0, 16'h3521);
        bus_write(2'd1, 16'h0A05);
        bus_write(2'd2, 16'hF00A);
        chk_read("R1 reg0", 2'd0, 16'h3521);
        chk_read("R1 reg1", 2'd1, 16'h0A05);
        chk_read("R1 reg2", 2'd2, 16'hF00A);

        // Vector table: priority resolution in level mode
        for (int i = 0; i < 12; i++) begin
            @(negedge clk);
            irq_n  = VEC[i][29:26];
            periph = VEC[i][25:10];
            @(negedge clk);
            chk_out($sformatf("R2/R3/R4/R9 vector %0d", i), VEC[i][9], int'(VEC[i][8:5]), int'(VEC[i][4:0]));
        end

        // R13: request and write timing
        irq_n = 4'b1101;
        @(negedge clk);
        chk_out("R13 request one clock", 1'b1, 1, 2);
        bus_write(2'd0, 16'h35F1);
        chk_out("R13 old rank right after write", 1'b1, 1, 2);
        @(negedge clk);
        chk_out("R13 new rank one clock later", 1'b1, 1, 15);

        // R6: software standby retains and holds
        sw_standby = 1'b1;
        irq_n = 4'b1111;
        @(negedge clk);
        chk_out("R6 held 1", 1'b1, 1, 15);
        @(negedge clk);
        chk_out("R6 held 2", 1'b1, 1, 15);
        chk_read("R6 reg0 kept", 2'd0, 16'h35F1);
        sw_standby = 1'b0;
        @(negedge clk);
        chk_out("R6 released", 1'b0, 0, 0);

        // R7 / R8: control register
        bus_write(2'd3, 16'h7E0F);
        chk_read("R7 R8 ctrl read-only and reserved", 2'd3, 16'h8000);
        bus_write(2'd3, 16'hFFFF);
        chk_read("R8 ctrl modes", 2'd3, 16'h81F0);
        bus_write(2'd3, 16'h0080);
        chk_read("R8 IRQ0 edge only", 2'd3, 16'h8080);

        // R10: IRQ0 falling edge latched until acknowledge
        @(negedge clk);
        irq_n = 4'b1110;
        @(negedge clk);
        irq_n = 4'b1111;
        chk_out("R10 edge caught", 1'b1, 0, 1);
        @(negedge clk);
        chk_out("R10 edge held", 1'b1, 0, 1);
        ack = 1'b1; ack_src = 4'd0;
        @(negedge clk);
        ack = 1'b0;
        @(negedge clk);
        chk_out("R10 cleared by ack", 1'b0, 0, 0);

        // R9: level mode pulse is not remembered
        irq_n = 4'b1101;
        @(negedge clk);
        chk_out("R9 level active", 1'b1, 1, 15);
        irq_n = 4'b1111;
        @(negedge clk);
        chk_out("R9 level released", 1'b0, 0, 0);

        // R11 / R12: NMI falling edge
        irq_n = 4'b1011;
        @(negedge clk);
        chk_out("R12 maskable before NMI", 1'b1, 2, 5);
        nmi_pin = 1'b0;
        @(negedge clk);
        chk_out("R12 NMI wins", 1'b1, 12, 16);
        chk_read("R7 NMI level low", 2'd3, 16'h0080);
        nmi_pin = 1'b1;
        @(negedge clk);
        chk_out("R11 NMI latched", 1'b1, 12, 16);
        ack = 1'b1; ack_src = 4'd12;
        @(negedge clk);
        ack = 1'b0;
        @(negedge clk);
        chk_out("R11 NMI acknowledged", 1'b1, 2, 5);

        // R11: NMI rising edge mode
        bus_write(2'd3, 16'h0180);
        nmi_pin = 1'b0;
        @(negedge clk);
        chk_out("R11 falling ignored in rising mode", 1'b1, 2, 5);
        nmi_pin = 1'b1;
        @(negedge clk);
        chk_out("R11 rising edge caught", 1'b1, 12, 16);
        ack = 1'b1; ack_src = 4'd12;
        irq_n = 4'b1111;
        @(negedge clk);
        ack = 1'b0;
        @(negedge clk);
        chk_out("R11 rising cleared", 1'b0, 0, 0);

        // R5: hardware standby clears everything
        hw_standby = 1'b1;
        @(negedge clk);
        hw_standby = 1'b0;
        chk_read("R5 standby reg0", 2'd0, 16'h0000);
        chk_read("R5 standby reg1", 2'd1, 16'h0000);
        chk_read("R5 standby reg2", 2'd2, 16'h0000);
        chk_read("R5 standby ctrl", 2'd3, 16'h8000);
        irq_n = 4'b1101;
        @(negedge clk);
        chk_out("R5 ranks cleared", 1'b0, 0, 0);
        irq_n = 4'b1111;

        finish_run();
    end
endmodule